// File: doc/BRIEF.md
# Three-Level 2D Wavelet Quadrant Engine

This engine computes one level of a separable two-dimensional integer wavelet decomposition per window position. An upstream feeder supplies a complete 5x5 neighbourhood of 16-bit signed pixels together with a valid strobe. The window centre sits on even image coordinates, so successive windows move by two pixels in each direction. For every accepted window the engine produces the four subband coefficients in the same output cycle. It also presents a tag that gives the level and the coefficient row and column within that level's quadrant.

A start pulse arms the engine at level 0 with the full image. The engine walks the window positions in row-major order. When the last position of a quadrant has been accepted, the engine moves on to the next level. Each later level covers only the low-low quadrant of the previous one, so the width and height halve. After the third level the engine goes idle until the next start. Pixels that overlap between neighbouring windows are kept by the feeder. The engine needs each window only once and never asks for data again. Border taps that fall outside the current quadrant are replaced inside the engine by the nearest in-range sample.

Top module: `wv_quad_engine`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `pass_done` are low.
- R2: Windows presented before any start pulse are ignored and produce no output.
- R3: Each row is first filtered with the low-pass taps (-1,2,6,2,-1) and the high-pass taps (0,-1,2,-1,0), over window column offsets 0..4. `out_ll` is the low-pass column filter of the row low-pass results, arithmetically shifted right by 6. Pixel (r,c) of the window sits at `win_pix[(r*5+c)*16 +: 16]`, with r the row offset and c the column offset, and the centre is at (2,2).
- R4: `out_lh` is the high-pass column filter of the row low-pass results, shifted right by 4. `out_hl` is the low-pass column filter of the row high-pass results, shifted right by 4. `out_hh` is the high-pass column filter of the row high-pass results, shifted right by 2. All shifts are arithmetic, so they floor.
- R5: The four coefficients and the tag appear together, exactly 2 clock cycles after the accepting window edge.
- R6: A tap whose image coordinate falls outside the current quadrant takes the value of the nearest in-range sample of the same window. Column c maps to image x = 2*col + c - 2, and row r maps to y = 2*row + r - 2.
- R7: Within a level, the tags run row-major. There are (16>>level)/2 columns and the same number of rows, the column advances first, and windows with `win_valid` low are not counted.
- R8: `pass_done` is high for exactly one cycle, together with the coefficients of the last window of each level.
- R9: After three levels the engine is idle, and further windows produce no output until the next start.
- R10: A start pulse restarts the scan at level 0, row 0, column 0, even in the middle of a scan. A window offered in the same cycle as start is ignored.
- R11: Full-scale inputs (-32768 and 32767) give exact results in the 18-bit signed outputs, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the engine at level 0, position 0 |
| win_valid | input | 1 | A window is offered this cycle |
| win_pix | input | 400 | 5x5 pixel window, 16-bit signed each |
| out_valid | output | 1 | Coefficients and tag are valid |
| out_ll | output | 18 | Low-low coefficient |
| out_lh | output | 18 | Horizontal-low, vertical-high coefficient |
| out_hl | output | 18 | Horizontal-high, vertical-low coefficient |
| out_hh | output | 18 | High-high coefficient |
| out_level | output | 2 | Decomposition level of this output |
| out_row | output | 3 | Coefficient row within the quadrant |
| out_col | output | 3 | Coefficient column within the quadrant |
| pass_done | output | 1 | Last coefficient set of the current level |

## Verification
The bound checker watches four things on every cycle. It checks that `pass_done` lasts a single cycle and always comes with valid data. It checks that every output was preceded by a window exactly two cycles earlier. It checks that the level and column tags stay within the quadrant of that level. The coefficient values, the border replacement, the row-major order, the three-level handover, and the handling of windows while idle or at a restart can only be shown by the bench's scenarios. The bench compares every output with its own integer model of the filters.

// File: rtl/wv_pkg.sv
package wv_pkg;
   localparam int WIN = 5;
   localparam int MID = 2;

   // Window offset that supplies tap k once the image coordinate is clamped.
   function automatic int tap_src(input int k, input int centre, input int size);
      int p;
      p = centre + k - MID;
      if (p < 0) p = 0;
      if (p > size - 1) p = size - 1;
      return p - centre + MID;
   endfunction
endpackage

// File: rtl/wv_walker.sv
module wv_walker #(
   parameter int IMG_W = 16,
   parameter int IMG_H = 16,
   parameter int LEVELS = 3,
   parameter int LVL_W = 2,
   parameter int POS_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             win_valid,
   output logic             accept,
   output logic             last,
   output logic [LVL_W-1:0] level,
   output logic [POS_W-1:0] row,
   output logic [POS_W-1:0] col
);
   localparam int DW = POS_W + 1;

   logic          active;
   logic [DW-1:0] ncols, nrows;
   logic          col_last, row_last;

   always_comb begin
      ncols = DW'((IMG_W >> level) >> 1);
      nrows = DW'((IMG_H >> level) >> 1);
   end

   assign col_last = ({1'b0, col} == ncols - DW'(1));
   assign row_last = ({1'b0, row} == nrows - DW'(1));
   assign accept   = win_valid & active & ~start;
   assign last     = accept & col_last & row_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         level  <= '0;
         row    <= '0;
         col    <= '0;
      end else if (start) begin
         active <= 1'b1;
         level  <= '0;
         row    <= '0;
         col    <= '0;
      end else if (accept) begin
         if (col_last) begin
            col <= '0;
            if (row_last) begin
               row <= '0;
               if (level == LVL_W'(LEVELS - 1)) active <= 1'b0;
               else level <= level + LVL_W'(1);
            end else begin
               row <= row + POS_W'(1);
            end
         end else begin
            col <= col + POS_W'(1);
         end
      end
   end
endmodule

// File: rtl/wv_row_filt.sv
module wv_row_filt
   import wv_pkg::*;
#(
   parameter int PIX_W = 16,
   parameter int IMG_W = 16,
   parameter int IMG_H = 16,
   parameter int LVL_W = 2,
   parameter int POS_W = 3,
   parameter int RW = PIX_W + 4
)(
   input  logic [WIN*WIN*PIX_W-1:0] pix,
   input  logic [LVL_W-1:0]         level,
   input  logic [POS_W-1:0]         row,
   input  logic [POS_W-1:0]         col,
   output logic [WIN*RW-1:0]        lo_rows,
   output logic [WIN*RW-1:0]        hi_rows
);
   int qw, qh, cx, cy;
   assign qw = IMG_W >> level;
   assign qh = IMG_H >> level;
   assign cx = 2 * int'(col);
   assign cy = 2 * int'(row);

   for (genvar gr = 0; gr < WIN; gr++) begin : g_row
      int sr;
      logic signed [RW-1:0] tp [WIN];
      assign sr = tap_src(gr, cy, qh);
      for (genvar gk = 0; gk < WIN; gk++) begin : g_tap
         int sk;
         logic [PIX_W-1:0] px;
         assign sk = tap_src(gk, cx, qw);
         assign px = pix[(sr * WIN + sk) * PIX_W +: PIX_W];
         assign tp[gk] = {{(RW - PIX_W){px[PIX_W-1]}}, px};
      end
      assign lo_rows[gr*RW +: RW] = (tp[1] <<< 1) + (tp[2] <<< 2) + (tp[2] <<< 1)
                                  + (tp[3] <<< 1) - tp[0] - tp[4];
      assign hi_rows[gr*RW +: RW] = (tp[2] <<< 1) - tp[1] - tp[3];
   end
endmodule

// File: rtl/wv_col_filt.sv
module wv_col_filt #(
   parameter int RW = 20,
   parameter int CW = 18
)(
   input  logic [5*RW-1:0] lo_rows,
   input  logic [5*RW-1:0] hi_rows,
   output logic [CW-1:0]   ll,
   output logic [CW-1:0]   lh,
   output logic [CW-1:0]   hl,
   output logic [CW-1:0]   hh
);
   localparam int AW = RW + 4;

   logic signed [AW-1:0] a [5];
   logic signed [AW-1:0] b [5];
   logic signed [AW-1:0] s_ll, s_lh, s_hl, s_hh;

   for (genvar g = 0; g < 5; g++) begin : g_ext
      assign a[g] = {{4{lo_rows[g*RW+RW-1]}}, lo_rows[g*RW +: RW]};
      assign b[g] = {{4{hi_rows[g*RW+RW-1]}}, hi_rows[g*RW +: RW]};
   end

   assign s_ll = (a[1] <<< 1) + (a[2] <<< 2) + (a[2] <<< 1) + (a[3] <<< 1) - a[0] - a[4];
   assign s_lh = (a[2] <<< 1) - a[1] - a[3];
   assign s_hl = (b[1] <<< 1) + (b[2] <<< 2) + (b[2] <<< 1) + (b[3] <<< 1) - b[0] - b[4];
   assign s_hh = (b[2] <<< 1) - b[1] - b[3];

   assign ll = CW'(s_ll >>> 6);
   assign lh = CW'(s_lh >>> 4);
   assign hl = CW'(s_hl >>> 4);
   assign hh = CW'(s_hh >>> 2);
endmodule

// File: rtl/wv_quad_engine.sv
module wv_quad_engine
   import wv_pkg::*;
#(
   parameter int PIX_W = 16,
   parameter int IMG_W = 16,
   parameter int IMG_H = 16,
   parameter int LEVELS = 3,
   parameter int PIPE_ROW = 1,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int POS_W = $clog2(((IMG_W > IMG_H) ? IMG_W : IMG_H) / 2),
   localparam int CW = PIX_W + 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     win_valid,
   input  logic [WIN*WIN*PIX_W-1:0] win_pix,
   output logic                     out_valid,
   output logic [CW-1:0]            out_ll,
   output logic [CW-1:0]            out_lh,
   output logic [CW-1:0]            out_hl,
   output logic [CW-1:0]            out_hh,
   output logic [LVL_W-1:0]         out_level,
   output logic [POS_W-1:0]         out_row,
   output logic [POS_W-1:0]         out_col,
   output logic                     pass_done
);
   localparam int RW = PIX_W + 4;

   if ((IMG_W >> (LEVELS - 1)) < 4 || (IMG_H >> (LEVELS - 1)) < 4)
      $error("deepest quadrant must be at least 4x4");
   if ((IMG_W % (1 << LEVELS)) != 0 || (IMG_H % (1 << LEVELS)) != 0)
      $error("image size must divide by 2**LEVELS");
   if (PIPE_ROW != 0 && PIPE_ROW != 1)
      $error("PIPE_ROW must be 0 or 1");

   logic             acc, acc_last;
   logic [LVL_W-1:0] w_level;
   logic [POS_W-1:0] w_row, w_col;
   logic [5*RW-1:0]  lo_c, hi_c;

   wv_walker #(.IMG_W(IMG_W), .IMG_H(IMG_H), .LEVELS(LEVELS), .LVL_W(LVL_W), .POS_W(POS_W))
   u_walk (.clk(clk), .rst_n(rst_n), .start(start), .win_valid(win_valid),
           .accept(acc), .last(acc_last), .level(w_level), .row(w_row), .col(w_col));

   wv_row_filt #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .LVL_W(LVL_W), .POS_W(POS_W), .RW(RW))
   u_row (.pix(win_pix), .level(w_level), .row(w_row), .col(w_col),
          .lo_rows(lo_c), .hi_rows(hi_c));

   logic             s1_v, s1_last;
   logic [5*RW-1:0]  s1_lo, s1_hi;
   logic [LVL_W-1:0] s1_level;
   logic [POS_W-1:0] s1_row, s1_col;

   if (PIPE_ROW == 1) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_last <= 1'b0;
         end else begin
            s1_v    <= acc;
            s1_last <= acc_last;
         end
         s1_lo    <= lo_c;
         s1_hi    <= hi_c;
         s1_level <= w_level;
         s1_row   <= w_row;
         s1_col   <= w_col;
      end
   end else begin : g_flow
      assign s1_v     = acc;
      assign s1_last  = acc_last;
      assign s1_lo    = lo_c;
      assign s1_hi    = hi_c;
      assign s1_level = w_level;
      assign s1_row   = w_row;
      assign s1_col   = w_col;
   end

   logic [CW-1:0] c_ll, c_lh, c_hl, c_hh;

   wv_col_filt #(.RW(RW), .CW(CW))
   u_col (.lo_rows(s1_lo), .hi_rows(s1_hi), .ll(c_ll), .lh(c_lh), .hl(c_hl), .hh(c_hh));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pass_done <= 1'b0;
         out_ll    <= '0;
         out_lh    <= '0;
         out_hl    <= '0;
         out_hh    <= '0;
         out_level <= '0;
         out_row   <= '0;
         out_col   <= '0;
      end else begin
         out_valid <= s1_v;
         pass_done <= s1_v & s1_last;
         if (s1_v) begin
            out_ll    <= c_ll;
            out_lh    <= c_lh;
            out_hl    <= c_hl;
            out_hh    <= c_hh;
            out_level <= s1_level;
            out_row   <= s1_row;
            out_col   <= s1_col;
         end
      end
   end
endmodule

// File: rtl/wv_quad_chk.sv
module wv_quad_chk #(
   parameter int IMG_W = 16,
   parameter int LEVELS = 3,
   parameter int LAT = 2,
   parameter int LVL_W = 2,
   parameter int POS_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             win_valid,
   input logic             out_valid,
   input logic             pass_done,
   input logic [LVL_W-1:0] out_level,
   input logic [POS_W-1:0] out_col
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   // R8
   done_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> out_valid);

   // R5
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(win_valid, LAT));

   // R9
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_level) < LEVELS));

   // R7
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_col) < ((IMG_W >> out_level) >> 1)));
endmodule

bind wv_quad_engine wv_quad_chk #(
   .IMG_W(IMG_W), .LEVELS(LEVELS), .LAT(PIPE_ROW + 1), .LVL_W(LVL_W), .POS_W(POS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .out_valid(out_valid),
   .pass_done(pass_done), .out_level(out_level), .out_col(out_col)
);

// File: tb/test_wv_quad_engine.sv
module test_wv_quad_engine;
   localparam int IMG = 16;
   localparam int NLV = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         win_valid = 1'b0;
   logic [399:0] win_pix = '0;
   logic         out_valid, pass_done;
   logic [17:0]  out_ll, out_lh, out_hl, out_hh;
   logic [1:0]   out_level;
   logic [2:0]   out_row, out_col;

   wv_quad_engine i_wv_quad_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .win_valid(win_valid), .win_pix(win_pix),
      .out_valid(out_valid), .out_ll(out_ll), .out_lh(out_lh), .out_hl(out_hl), .out_hh(out_hh),
      .out_level(out_level), .out_row(out_row), .out_col(out_col), .pass_done(pass_done));

   always #10 clk = ~clk;

   typedef struct {
      int lvl; int row; int col;
      longint ll; longint lh; longint hl; longint hh;
      bit last; bit edge_pos; int cyc;
   } exp_t;

   exp_t   q[$];
   int     n_chk = 0, n_fail = 0, cyc = 0, unexp = 0, done_cnt = 0;
   bit     m_act = 0;
   int     m_l = 0, m_r = 0, m_c = 0;
   int     cur[5][5];
   string  phase_req = "R3";
   bit     finished = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint sx18(input logic [17:0] v);
      return longint'($signed(v));
   endfunction

   function automatic int clip(input int v, input int n);
      return (v < 0) ? 0 : ((v > n - 1) ? n - 1 : v);
   endfunction

   function automatic exp_t model(input int lvl, input int row, input int col);
      exp_t e;
      longint rl[5], rh[5], v[5];
      int qs, x0, y0;
      qs = IMG >> lvl; x0 = 2 * col; y0 = 2 * row;
      for (int r = 0; r < 5; r++) begin
         int yi;
         yi = clip(y0 + r - 2, qs) - y0 + 2;
         for (int k = 0; k < 5; k++) begin
            int xi;
            xi = clip(x0 + k - 2, qs) - x0 + 2;
            v[k] = cur[yi][xi];
         end
         rl[r] = 6 * v[2] + 2 * (v[1] + v[3]) - (v[0] + v[4]);
         rh[r] = 2 * v[2] - v[1] - v[3];
      end
      e.ll = (6 * rl[2] + 2 * (rl[1] + rl[3]) - (rl[0] + rl[4])) >>> 6;
      e.lh = (2 * rl[2] - rl[1] - rl[3]) >>> 4;
      e.hl = (6 * rh[2] + 2 * (rh[1] + rh[3]) - (rh[0] + rh[4])) >>> 4;
      e.hh = (2 * rh[2] - rh[1] - rh[3]) >>> 2;
      e.lvl = lvl; e.row = row; e.col = col;
      e.edge_pos = (col == 0) || (row == 0) || (col == qs / 2 - 1) || (row == qs / 2 - 1);
      return e;
   endfunction

   function automatic int pick(input int mode);
      int u;
      u = int'($urandom);
      case (mode)
         1: return (u[0]) ? 32767 : -32768;
         2: return (u % 41) - 20;
         default: return int'($signed(u[15:0]));
      endcase
   endfunction

   task automatic put(input bit s, input bit v, input int mode);
      if (v) begin
         for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
               cur[r][c] = pick(mode);
               win_pix[(r * 5 + c) * 16 +: 16] = 16'(cur[r][c]);
            end
      end
      start = s;
      win_valid = v;
      if (s) begin
         m_act = 1; m_l = 0; m_r = 0; m_c = 0;
      end else if (v && m_act) begin
         exp_t e;
         int half;
         half = (IMG >> m_l) / 2;
         e = model(m_l, m_r, m_c);
         e.cyc = cyc;
         e.last = (m_c == half - 1) && (m_r == half - 1);
         q.push_back(e);
         if (m_c == half - 1) begin
            m_c = 0;
            if (m_r == half - 1) begin
               m_r = 0;
               if (m_l == NLV - 1) m_act = 0; else m_l++;
            end else m_r++;
         end else m_c++;
      end
      @(negedge clk);
      start = 0;
      win_valid = 0;
   endtask

   task automatic stream(input int n, input int mode, input bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom % 4 == 0)) put(0, 0, mode);
         put(0, 1, mode);
      end
   endtask

   task automatic drain();
      repeat (5) @(negedge clk);
   endtask

   // output monitor: compares every output against the model queue
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (pass_done && !out_valid) chk(0, "R8", "pass_done without data", 1, 0);
         if (out_valid) begin
            if (q.size() == 0) begin
               unexp++;
               chk(0, "R9", "output with no accepted window", 1, 0);
            end else begin
               exp_t e;
               string rl, rh, rt;
               e = q.pop_front();
               if (phase_req == "R11") begin rl = "R11"; rh = "R11"; end
               else if (e.edge_pos) begin rl = "R6"; rh = "R6"; end
               else begin rl = "R3"; rh = "R4"; end
               rt = (phase_req == "R10") ? "R10" : "R7";
               if (pass_done) done_cnt++;
               chk(cyc == e.cyc + 2, "R5", "latency cycle", cyc, e.cyc + 2);
               chk(out_level == 2'(e.lvl) && out_row == 3'(e.row) && out_col == 3'(e.col), rt,
                   "tag level*64+row*8+col", out_level * 64 + out_row * 8 + out_col,
                   e.lvl * 64 + e.row * 8 + e.col);
               chk(sx18(out_ll) == e.ll, rl, "LL", sx18(out_ll), e.ll);
               chk(sx18(out_lh) == e.lh, rh, "LH", sx18(out_lh), e.lh);
               chk(sx18(out_hl) == e.hl, rh, "HL", sx18(out_hl), e.hl);
               chk(sx18(out_hh) == e.hh, rh, "HH", sx18(out_hh), e.hh);
               chk(pass_done == e.last, "R8", "pass_done", pass_done, e.last);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20405));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
      chk(pass_done == 0, "R1", "pass_done in reset", pass_done, 0);
      rst_n = 1;
      @(negedge clk);
      chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
      chk(pass_done == 0, "R1", "pass_done after reset", pass_done, 0);

      // R2: windows before any start are ignored
      stream(6, 0, 0);
      drain();
      chk(unexp == 0 && out_valid == 0, "R2", "outputs before start", unexp, 0);

      // full three-level run, random pixels, random gaps
      phase_req = "R3";
      done_cnt = 0;
      put(1, 0, 0);
      stream(84, 0, 1);
      drain();
      chk(done_cnt == 3, "R9", "level completions", done_cnt, 3);
      chk(q.size() == 0, "R9", "pending outputs", q.size(), 0);

      // R9: idle after the third level
      stream(5, 0, 0);
      drain();
      chk(unexp == 0, "R9", "outputs while idle", unexp, 0);

      // R11: full-scale pixels
      phase_req = "R11";
      put(1, 0, 1);
      stream(84, 1, 0);
      drain();

      // R10: restart in the middle of a scan, window at the start cycle ignored
      phase_req = "R10";
      put(1, 0, 2);
      stream(10, 2, 0);
      put(1, 1, 2);
      done_cnt = 0;
      stream(84, 2, 1);
      drain();
      chk(done_cnt == 3, "R10", "level completions after restart", done_cnt, 3);
      chk(q.size() == 0, "R10", "pending outputs after restart", q.size(), 0);

      // more random runs
      phase_req = "R3";
      for (int k = 0; k < 3; k++) begin
         put(1, 0, 0);
         stream(84, k % 3, 1);
         drain();
      end
      chk(unexp == 0, "R2", "total unexpected outputs", unexp, 0);

      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule